// File: doc/BRIEF.md
# Double-Buffered Clock/Calendar Register Interface

This block is the host-facing register side of a clock/calendar, written as a synchronous design. It holds two copies of the time. The running copy advances by one second on each pulse of `sec_tick` while the oscillator bit is set. The visible copy is what the host reads and writes over a bus shaped like an asynchronous SRAM. That bus has active-low chip, output and write enables, a 5-bit address and an 8-bit data path. All bus inputs are taken to be synchronous to `clk`. Read data leaves on `bus_rdata`, and `bus_rdata_oe` tells the pad ring when to drive it. When the pad enable is low, the pins are high-impedance.

Clearing the update-enable bit freezes the visible copy, so software can read a consistent snapshot while the running copy keeps counting. A time field written during the freeze is marked. When updates are enabled again, each marked field is loaded into the running copy, and this is how software sets the clock. Asserting `pwr_fail` cuts the block off from the bus entirely.

Address map:

| Address | Contents |
|---|---|
| 0 | seconds |
| 1 | minutes |
| 2 | hours |
| 3 | date |
| 4 | month |
| 5 | year |
| 15 | control register |
| all others | general-purpose storage bytes |

Top module: `rtc_shadow_regs`

## Requirements
- R1: While `bus_ce_n` is high, `bus_rdata_oe` is low for any combination of `bus_oe_n` and `bus_we_n`.
- R2: With `bus_ce_n`=0, `bus_oe_n`=0 and `bus_we_n`=1 (and `pwr_fail`=0), `bus_rdata_oe` is high in the same cycle, and `bus_rdata` carries the byte at `bus_addr`.
- R3: With `bus_ce_n`=0 and both `bus_oe_n` and `bus_we_n` high, `bus_rdata_oe` is low.
- R4: Whenever `bus_ce_n` and `bus_we_n` are both low, `bus_rdata_oe` is low, even if `bus_oe_n` is low.
- R5: A write is active on every clock edge at which `bus_ce_n` and `bus_we_n` are both low. The address and data seen at the last such edge are stored at the first edge where either enable is high. The stored byte can be read from the next cycle on.
- R6: While `pwr_fail` is high, `bus_rdata_oe` is low and no write is stored. A write that is in progress when `pwr_fail` rises is discarded.
- R7: Each `sec_tick` pulse with the oscillator bit set advances the running copy, whatever the update-enable bit is. The fields are binary and roll over as follows: seconds 0–59, minutes 0–59, hours 0–23, month 1–12, year 0–99. The date runs from 1 to the month length: 30 for months 4, 6, 9 and 11; for month 2, 29 when year mod 4 is 0 and 28 otherwise; 31 for all other months.
- R8: While update-enable is set, the visible time fields follow the running copy with a lag of one clock. Host writes to addresses 0–5 then have no effect.
- R9: While update-enable is clear, the visible time fields hold their value. The only exception is host writes, which update the addressed field.
- R10: On the first clock after update-enable goes from clear to set, every field written during the freeze is loaded into the running copy. The unwritten fields keep their running values, and the visible copy takes the merged result.
- R11: With the oscillator bit clear, `sec_tick` does not change the time.
- R12: The control register is at address 15: bit 7 is update-enable, bit 6 is oscillator-enable, and the other bits read 0. After reset, control reads 0xC0, the time fields read 0,0,0,1,1,0 for addresses 0–5, and the storage bytes read 0. The storage bytes return what was last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse per second |
| pwr_fail | input | 1 | High when supply is below trip point; deselects the bus |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data from the host |
| bus_rdata | output | 8 | Read data toward the pads |
| bus_rdata_oe | output | 1 | Pad drive enable; pins float when low |

## Verification
The enable pins are swept through deselect, idle-select, read, and write with the output enable both low and high. This separates the decode priorities from one another. Writes are made with data that changes while the write is held, which shows that the byte from the last active edge is the one kept. A `pwr_fail` rise in the middle of a write shows that the write is aborted rather than stored late. The time path is exercised in three ways: with every field written during a freeze, with only the hour written while the seconds keep running, and with ticks applied during a freeze and with the oscillator off. Together these separate the merge on re-enable from simple copying. They also separate the leap-year February from the common-year February at the date rollover.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int RTC_DW   = 8;
  localparam int RTC_NF   = 6;
  localparam int F_SEC    = 0;
  localparam int F_MIN    = 1;
  localparam int F_HR     = 2;
  localparam int F_DATE   = 3;
  localparam int F_MON    = 4;
  localparam int F_YR     = 5;
  localparam int UPD_BIT  = 7;
  localparam int OSC_BIT  = 6;

  typedef logic [RTC_DW-1:0]             rtc_byte_t;
  typedef logic [RTC_NF-1:0][RTC_DW-1:0] rtc_tvec_t;

  // Length of a month; leap rule on a two-digit binary year.
  function automatic rtc_byte_t rtc_month_len(rtc_byte_t mon, rtc_byte_t yr);
    rtc_byte_t len;
    case (mon)
      8'd2:                     len = (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:  len = 8'd30;
      default:                  len = 8'd31;
    endcase
    return len;
  endfunction

  function automatic rtc_byte_t rtc_field_max(int idx, rtc_byte_t mon, rtc_byte_t yr);
    rtc_byte_t m;
    case (idx)
      F_SEC, F_MIN: m = 8'd59;
      F_HR:         m = 8'd23;
      F_DATE:       m = rtc_month_len(mon, yr);
      F_MON:        m = 8'd12;
      default:      m = 8'd99;
    endcase
    return m;
  endfunction

  function automatic rtc_byte_t rtc_field_min(int idx);
    return ((idx == F_DATE) || (idx == F_MON)) ? 8'd1 : 8'd0;
  endfunction

  // One-second step with ripple carry through the fields.
  function automatic rtc_tvec_t rtc_advance(rtc_tvec_t t);
    rtc_tvec_t n;
    logic      carry;
    n     = t;
    carry = 1'b1;
    for (int i = 0; i < RTC_NF; i++) begin
      if (carry) begin
        if (t[i] >= rtc_field_max(i, t[F_MON], t[F_YR])) begin
          n[i] = rtc_field_min(i);
        end else begin
          n[i]  = t[i] + 8'd1;
          carry = 1'b0;
        end
      end
    end
    return n;
  endfunction

  function automatic rtc_tvec_t rtc_reset_time();
    rtc_tvec_t t;
    t         = '0;
    t[F_DATE] = 8'd1;
    t[F_MON]  = 8'd1;
    return t;
  endfunction

endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_fail,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              rd_drive,
  output logic              wr_act,
  output logic              wr_commit,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  logic sel;
  logic pend_q;

  assign sel       = ~ce_n & ~pwr_fail;
  assign wr_act    = sel & ~we_n;
  assign rd_drive  = sel & ~oe_n & we_n;
  assign wr_commit = pend_q & ~wr_act & ~pwr_fail;

  // Hold the last active address/data; the write lands when it ends.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (pwr_fail) begin
      pend_q  <= 1'b0;
    end else if (wr_act) begin
      pend_q  <= 1'b1;
      wr_addr <= addr;
      wr_data <= din;
    end else begin
      pend_q  <= 1'b0;
    end
  end

  p_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !rd_drive);

  p_write_quiets_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !we_n) |-> !rd_drive);

  p_commit_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(wr_act));

  p_power_fail_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |-> (!rd_drive && !wr_commit));

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int CTRL_ADDR = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_commit,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [RTC_DW-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_hit,
  output logic [RTC_DW-1:0] rd_data
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  rtc_tvec_t         int_q, ext_q, src, nxt_int;
  logic [RTC_NF-1:0] dirty_q, field_sel, rd_sel;
  logic              upd_en_q, osc_en_q, upd_prev_q;
  logic              load_evt, adv_evt, time_wr_evt, ctrl_wr_evt;

  assign load_evt    = upd_en_q & ~upd_prev_q;
  assign adv_evt     = tick & osc_en_q;
  assign time_wr_evt = wr_commit & (|field_sel);
  assign ctrl_wr_evt = wr_commit & (wr_addr == CTRL_A);

  generate
    for (genvar g = 0; g < RTC_NF; g++) begin : g_field
      assign field_sel[g] = (wr_addr == ADDR_W'(g));
      assign rd_sel[g]    = (rd_addr == ADDR_W'(g));
      assign src[g]       = (load_evt && dirty_q[g]) ? ext_q[g] : int_q[g];
    end
  endgenerate

  assign nxt_int = adv_evt ? rtc_advance(src) : src;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q      <= rtc_reset_time();
      ext_q      <= rtc_reset_time();
      dirty_q    <= '0;
      upd_en_q   <= 1'b1;
      osc_en_q   <= 1'b1;
      upd_prev_q <= 1'b1;
    end else begin
      int_q      <= nxt_int;
      upd_prev_q <= upd_en_q;
      if (upd_en_q) begin
        ext_q <= src;
      end else if (time_wr_evt) begin
        for (int i = 0; i < RTC_NF; i++) begin
          if (field_sel[i]) ext_q[i] <= wr_data;
        end
      end
      if (load_evt) begin
        dirty_q <= '0;
      end else if (time_wr_evt && !upd_en_q) begin
        dirty_q <= dirty_q | field_sel;
      end
      if (ctrl_wr_evt) begin
        upd_en_q <= wr_data[UPD_BIT];
        osc_en_q <= wr_data[OSC_BIT];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < RTC_NF; i++) begin
      if (rd_sel[i]) rd_data = ext_q[i];
    end
    if (rd_addr == CTRL_A) begin
      rd_data          = '0;
      rd_data[UPD_BIT] = upd_en_q;
      rd_data[OSC_BIT] = osc_en_q;
    end
  end

  assign rd_hit = (|rd_sel) | (rd_addr == CTRL_A);

  p_tick_moves_time_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && !load_evt) |=> (int_q != $past(int_q)));

  p_frozen_snapshot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en_q && !time_wr_evt) |=> $stable(ext_q));

  p_marks_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (dirty_q == '0));

  p_osc_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en_q && !load_evt) |=> $stable(int_q));

endmodule

// File: rtl/rtc_scratch_ram.sv
module rtc_scratch_ram #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
  import rtc_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int CTRL_ADDR = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              pwr_fail,
  input  logic              bus_ce_n,
  input  logic              bus_oe_n,
  input  logic              bus_we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [RTC_DW-1:0] bus_wdata,
  output logic [RTC_DW-1:0] bus_rdata,
  output logic              bus_rdata_oe
);

  logic              rd_drive, wr_act, wr_commit, core_hit;
  logic [ADDR_W-1:0] wr_addr;
  logic [RTC_DW-1:0] wr_data, core_rdata, ram_rdata;

  rtc_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(RTC_DW)) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_fail  (pwr_fail),
    .ce_n      (bus_ce_n),
    .oe_n      (bus_oe_n),
    .we_n      (bus_we_n),
    .addr      (bus_addr),
    .din       (bus_wdata),
    .rd_drive  (rd_drive),
    .wr_act    (wr_act),
    .wr_commit (wr_commit),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  rtc_time_core #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sec_tick),
    .wr_commit (wr_commit),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (bus_addr),
    .rd_hit    (core_hit),
    .rd_data   (core_rdata)
  );

  rtc_scratch_ram #(.ADDR_W(ADDR_W), .DATA_W(RTC_DW)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_commit),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (bus_addr),
    .rdata (ram_rdata)
  );

  assign bus_rdata    = core_hit ? core_rdata : ram_rdata;
  assign bus_rdata_oe = rd_drive;

  p_no_drive_while_writing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_act |-> !bus_rdata_oe);

endmodule

// File: tb/rtc_shadow_regs_tb_top.sv
module rtc_shadow_regs_tb_top;

  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, pf = 1'b0;
  logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [4:0] addr = '0;
  logic [7:0] wd = '0;
  logic [7:0] rd;
  logic       rd_oe;

  always #4 clk = ~clk;   // 125 MHz

  rtc_shadow_regs dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(tick), .pwr_fail(pf),
    .bus_ce_n(ce_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
    .bus_addr(addr), .bus_wdata(wd), .bus_rdata(rd), .bus_rdata_oe(rd_oe)
  );

  int    n_chk = 0, n_err = 0;
  string cur_tag = "R12";

  // ---------------- behavioural reference ----------------
  int m_run[6], m_vis[6], m_ram[32];
  bit m_mark[6];
  bit m_upd, m_osc, m_prev, m_pend;
  int m_wa, m_wd;

  function automatic int month_days(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 6; i++) begin
      m_run[i] = (i == 3 || i == 4) ? 1 : 0;
      m_vis[i] = m_run[i];
      m_mark[i] = 0;
    end
    for (int i = 0; i < 32; i++) m_ram[i] = 0;
    m_upd = 1; m_osc = 1; m_prev = 1; m_pend = 0; m_wa = 0; m_wd = 0;
  endtask

  task automatic model_step();
    int  s[6], nv[6], hi, lo;
    bit  wa, cm, ld, carry, old_upd;
    wa = !ce_n && !we_n && !pf;
    cm = m_pend && !wa && !pf;
    ld = m_upd && !m_prev;
    old_upd = m_upd;
    for (int i = 0; i < 6; i++) begin
      s[i]  = (ld && m_mark[i]) ? m_vis[i] : m_run[i];
      nv[i] = m_upd ? s[i] : m_vis[i];
    end
    for (int i = 0; i < 6; i++) m_run[i] = s[i];
    if (tick && m_osc) begin
      carry = 1;
      for (int i = 0; i < 6; i++) begin
        if (carry) begin
          hi = (i < 2) ? 59 : (i == 2) ? 23 : (i == 3) ? month_days(s[4], s[5]) : (i == 4) ? 12 : 99;
          lo = (i == 3 || i == 4) ? 1 : 0;
          if (s[i] >= hi) m_run[i] = lo;
          else begin m_run[i] = s[i] + 1; carry = 0; end
        end
      end
    end
    if (ld) for (int i = 0; i < 6; i++) m_mark[i] = 0;
    if (cm) begin
      m_ram[m_wa] = m_wd;
      if (m_wa < 6 && !m_upd) begin nv[m_wa] = m_wd; m_mark[m_wa] = 1; end
      if (m_wa == 15) begin m_upd = m_wd[7]; m_osc = m_wd[6]; end
    end
    m_prev = old_upd;
    for (int i = 0; i < 6; i++) m_vis[i] = nv[i];
    if (pf) m_pend = 0;
    else if (wa) begin m_pend = 1; m_wa = addr; m_wd = wd; end
    else m_pend = 0;
  endtask

  function automatic int model_read(int a);
    if (a < 6) return m_vis[a];
    if (a == 15) return (m_upd ? 128 : 0) + (m_osc ? 64 : 0);
    return m_ram[a];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  task automatic check(int act, int exp, string tag, string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Every-cycle comparison against the reference.
  bit    exp_oe;
  string mode_tag;
  always @(negedge clk) begin
    if (rst_n) begin
      exp_oe   = !pf && !ce_n && !oe_n && we_n;
      mode_tag = pf ? "R6" : ce_n ? "R1" : !we_n ? "R4" : oe_n ? "R3" : "R2";
      check(int'(rd_oe), int'(exp_oe), mode_tag, "pad enable vs model");
      if (exp_oe) check(int'(rd), model_read(int'(addr)), cur_tag, "read data vs model");
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic bus_wr(int a, int d);
    @(posedge clk); #1 ce_n = 0; we_n = 0; addr = 5'(a); wd = 8'(d);
    @(posedge clk); #1 ce_n = 1; we_n = 1;
    @(posedge clk);
  endtask

  task automatic bus_wr_change(int a, int d1, int d2, bit oe_low);
    @(posedge clk); #1 ce_n = 0; we_n = 0; oe_n = !oe_low; addr = 5'(a); wd = 8'(d1);
    @(posedge clk); #1 wd = 8'(d2);
    @(posedge clk); #1 ce_n = 1; we_n = 1; oe_n = 1;
    @(posedge clk);
  endtask

  task automatic rd_expect(int a, int exp, string tag);
    @(posedge clk); #1 ce_n = 0; oe_n = 0; we_n = 1; addr = 5'(a);
    @(negedge clk);
    check(int'(rd_oe), 1, tag, "read enable");
    check(int'(rd), exp, tag, "read data");
    @(posedge clk); #1 ce_n = 1; oe_n = 1;
  endtask

  task automatic pulse_tick(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1 tick = 1;
      @(posedge clk); #1 tick = 0;
    end
  endtask

  task automatic set_time(int s, int mi, int h, int dt, int mo, int y);
    bus_wr(0, s); bus_wr(1, mi); bus_wr(2, h);
    bus_wr(3, dt); bus_wr(4, mo); bus_wr(5, y);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    cur_tag = "R12";                       // reset state
    rd_expect(0, 0, "R12"); rd_expect(3, 1, "R12"); rd_expect(4, 1, "R12");
    rd_expect(15, 8'hC0, "R12"); rd_expect(20, 0, "R12");

    cur_tag = "R2";                        // storage write/read
    bus_wr(20, 8'h5A); rd_expect(20, 8'h5A, "R2");

    cur_tag = "R5";                        // data changing during write, OE low (R4)
    bus_wr_change(21, 8'h33, 8'h44, 1'b1); rd_expect(21, 8'h44, "R5");

    cur_tag = "R8";                        // time write while updating is ignored
    bus_wr(0, 30); rd_expect(0, 0, "R8");

    cur_tag = "R7";
    pulse_tick(3); rd_expect(0, 3, "R7");

    cur_tag = "R9";                        // freeze, set every field
    bus_wr(15, 8'h40);
    set_time(59, 59, 23, 28, 2, 1);
    rd_expect(0, 59, "R9");
    pulse_tick(3); rd_expect(0, 59, "R9");
    cur_tag = "R10";
    bus_wr(15, 8'hC0);
    rd_expect(0, 59, "R10"); rd_expect(3, 28, "R10");
    cur_tag = "R7";                        // common-year February rollover
    pulse_tick(1);
    rd_expect(0, 0, "R7"); rd_expect(1, 0, "R7"); rd_expect(2, 0, "R7");
    rd_expect(3, 1, "R7"); rd_expect(4, 3, "R7"); rd_expect(5, 1, "R7");

    cur_tag = "R10";                       // partial set: only the hour
    bus_wr(15, 8'h40); bus_wr(2, 7);
    pulse_tick(2); rd_expect(0, 0, "R9");
    bus_wr(15, 8'hC0);
    rd_expect(0, 2, "R10"); rd_expect(2, 7, "R10");

    cur_tag = "R11";                       // oscillator off
    bus_wr(15, 8'h80); pulse_tick(4);
    rd_expect(0, 2, "R11"); rd_expect(15, 8'h80, "R12");

    cur_tag = "R7";                        // leap-year February
    bus_wr(15, 8'h40);
    set_time(59, 59, 23, 28, 2, 4);
    bus_wr(15, 8'hC0); pulse_tick(1);
    rd_expect(3, 29, "R7"); rd_expect(4, 2, "R7");

    cur_tag = "R6";                        // power fail
    @(posedge clk); #1 pf = 1;
    bus_wr(20, 8'h11);
    @(posedge clk); #1 ce_n = 0; oe_n = 0; addr = 20;
    @(negedge clk); check(int'(rd_oe), 0, "R6", "pad enable under power fail");
    @(posedge clk); #1 ce_n = 1; oe_n = 1; pf = 0;
    rd_expect(20, 8'h5A, "R6");
    @(posedge clk); #1 ce_n = 0; we_n = 0; addr = 22; wd = 8'h77;
    @(posedge clk); #1 pf = 1;
    @(posedge clk); #1 ce_n = 1; we_n = 1;
    @(posedge clk); #1 pf = 0;
    rd_expect(22, 0, "R6");

    cur_tag = "R3";                        // selected, idle
    @(posedge clk); #1 ce_n = 0; oe_n = 1; we_n = 1; addr = 20;
    @(negedge clk); check(int'(rd_oe), 0, "R3", "idle select");
    cur_tag = "R1";
    @(posedge clk); #1 ce_n = 1; oe_n = 0;
    @(negedge clk); check(int'(rd_oe), 0, "R1", "deselect with OE low");
    @(posedge clk); #1 we_n = 0;
    @(negedge clk); check(int'(rd_oe), 0, "R1", "deselect with WE low");
    @(posedge clk); #1 we_n = 1; oe_n = 1;
    rd_expect(20, 8'h5A, "R1");

    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule